// File: doc/BRIEF.md
# Debug Chain Register Access Router

This block sits between a debug transport and the debug-facing resources of a processor core. The transport hands it one request at a time: an operation (read, write or chain select), an address and a 32-bit data word. The block remembers which chain is currently selected and decodes each read or write against that chain. Depending on the chain and the address, the request goes to the core's debug, special or general registers, to a trace stub, to a small set of development-control registers held inside the block, or to a byte-wide memory port.

Every request ends with a one-cycle `rsp_done` pulse, a 2-bit error code and, for reads, a 32-bit result. Error codes are 0 for success, 1 for an invalid address, 2 for an access error and 3 for an invalid chain. The development set includes a CPU control register. Its bit 0 holds the core in reset and its bit 1 requests a stall. Clearing a set bit 0 by a write produces a one-cycle reset pulse. Memory words move as four byte beats, most significant byte first, at consecutive byte addresses.

Top module: `dbgr_top`

## Requirements
- R1: A chain-select request (op 2) takes its chain from `req_wdata`. Value 0 selects the core-debug chain, 1 trace, 2 development and 3 memory, each with error 0. Any value of 4 or more returns error 3 and keeps the previous chain. The chain after reset is the core-debug chain.
- R2: A request on any chain other than memory gives `rsp_done` for one cycle, in the cycle after the request. A memory request with a valid address gives `rsp_done` five cycles after the request. Whenever the error code is non-zero, `rsp_rdata` is 0.
- R3: On the trace chain, a read (op 0) returns 0 with error 0. A write (op 1) returns error 2.
- R4: On the core-debug chain, address bits 15:11 are a group and bits 10:0 an offset. Group 6 goes to the core port with `core_sel`=0 and the offset on `core_addr`, with error 0. Any group other than 0 and 6 returns error 1 and raises no core strobe.
- R5: In group 0, offsets 1 to 31 reach the core port with `core_sel`=1 and the offset as `core_addr`. Offsets 0x400 to 0x41F reach it with `core_sel`=2 and the offset minus 0x400 as `core_addr`. Reads return `core_rdata` from the request cycle.
- R6: In group 0, a write to offset 0 returns error 2 with no `core_we`. A read of offset 0 is a special-register read with error 0.
- R7: In group 0, reads of offsets 0x600 to 0x61F return 0 with error 0, and writes there return error 0. Neither raises a core strobe. Every other group-0 offset not covered by R5 and R6 returns error 1.
- R8: `npc_clear` is high in exactly the request cycle of a write to special-register offset `NPC_OFF` (default 16).
- R9: On the development chain, addresses 0 to `DEV_NREGS`-1 (default 4) are read/write scratch registers, reset to 0. Address `DEV_NREGS` is the CPU control register. Higher addresses return error 1.
- R10: A write to the control register drives `cpu_reset_hold` from data bit 0 and `cpu_stall_req` from data bit 1, starting the cycle after the write. Reading the control register returns these two bits in bits 1:0, with all other bits 0.
- R11: `cpu_reset_pulse` is high for exactly the one cycle after a control write that changes the reset-hold bit from 1 to 0. It stays low for every other write.
- R12: On the memory chain, word address A becomes byte address 4A. The four beats present bytes 4A to 4A+3 in that order on `mem_addr`. A write sends data bits 31:24 first and bits 7:0 last. A read assembles `mem_rdata` the same way.
- R13: A memory request whose word address is `MEM_WORDS` (default 1024) or higher returns error 1 in the next cycle, with no memory beat.
- R14: A request presented while a memory transfer is in progress is ignored. It produces no done pulse and changes no memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 chain select |
| req_addr | input | 16 | Request address, interpreted per chain |
| req_wdata | input | 32 | Write data or chain number |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | Completion error code |
| rsp_rdata | output | 32 | Read result |
| core_re | output | 1 | Core register read strobe |
| core_we | output | 1 | Core register write strobe |
| core_sel | output | 2 | 0 debug regs, 1 special regs, 2 general regs |
| core_addr | output | 11 | Core register offset or index |
| core_wdata | output | 32 | Core write data |
| core_rdata | input | 32 | Core read data, valid in the strobe cycle |
| npc_clear | output | 1 | Clear pending exception state |
| mem_valid | output | 1 | Memory byte beat active |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 18 | Byte address of the beat |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the beat cycle |
| cpu_reset_hold | output | 1 | Holds the core in reset |
| cpu_stall_req | output | 1 | Requests a core stall |
| cpu_reset_pulse | output | 1 | One-shot core reset |

## Verification
A corrupted chain register shows up at the next read or write. That request reaches the wrong target: a core strobe where none is due, a trace zero, or a memory beat. The error code and strobe pattern expose this one cycle after the request. A memory sequencer that slips a beat or shifts in the wrong direction shows a misordered word on the first read of a known pattern. It also shows a done pulse off the fifth cycle. A stale reset-hold bit shows up as a missing or extra `cpu_reset_pulse` right after the control write. A corrupted scratch register shows up at its next read-back.

// File: rtl/dbgr_pkg.sv
`timescale 1ns/1ps
package dbgr_pkg;

    typedef enum logic [1:0] {
        ERR_OK     = 2'd0,
        ERR_ADDR   = 2'd1,
        ERR_ACCESS = 2'd2,
        ERR_CHAIN  = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        CH_CORE  = 2'd0,
        CH_TRACE = 2'd1,
        CH_DEV   = 2'd2,
        CH_MEM   = 2'd3
    } chain_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CHAIN = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CSEL_DREG = 2'd0,
        CSEL_SPR  = 2'd1,
        CSEL_GPR  = 2'd2,
        CSEL_NONE = 2'd3
    } csel_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CORE,
        TGT_ZERO,
        TGT_DEV,
        TGT_MEM,
        TGT_CHAIN
    } tgt_e;

    localparam int unsigned OFF_W     = 11;
    localparam int unsigned GRP_DEBUG = 6;
    localparam int unsigned GRP_CPU   = 0;
    localparam int unsigned NUM_CHAIN = 4;

endpackage

// File: rtl/dbgr_decode.sv
`timescale 1ns/1ps
module dbgr_decode
    import dbgr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned MEM_WORDS = 1024,
    parameter int unsigned DEV_NREGS = 4
) (
    input  chain_e              chain,
    input  op_e                 op,
    input  logic [ADDR_W-1:0]   addr,
    output tgt_e                tgt,
    output err_e                err,
    output csel_e               csel,
    output logic [OFF_W-1:0]    coff,
    output logic [ADDR_W+1:0]   mem_baddr
);
    localparam int unsigned GRP_W = ADDR_W - OFF_W;

    logic [GRP_W-1:0] grp;
    logic [OFF_W-1:0] off;
    logic             is_wr;

    assign grp       = addr[ADDR_W-1:OFF_W];
    assign off       = addr[OFF_W-1:0];
    assign is_wr     = (op == OP_WRITE);
    assign mem_baddr = {addr, 2'b00};

    always_comb begin
        tgt  = TGT_NONE;
        err  = ERR_OK;
        csel = CSEL_NONE;
        coff = '0;
        if (op == OP_CHAIN) begin
            tgt = TGT_CHAIN;
        end else if (op == OP_RSVD) begin
            err = ERR_ACCESS;
        end else begin
            unique case (chain)
                CH_TRACE: begin
                    if (is_wr) err = ERR_ACCESS;
                    else       tgt = TGT_ZERO;
                end
                CH_CORE: begin
                    if (grp == GRP_W'(GRP_DEBUG)) begin
                        tgt  = TGT_CORE;
                        csel = CSEL_DREG;
                        coff = off;
                    end else if (grp == GRP_W'(GRP_CPU)) begin
                        if (off == '0 && is_wr) begin
                            err = ERR_ACCESS;
                        end else if (off < 11'd32) begin
                            tgt  = TGT_CORE;
                            csel = CSEL_SPR;
                            coff = off;
                        end else if (off >= 11'h400 && off <= 11'h41F) begin
                            tgt  = TGT_CORE;
                            csel = CSEL_GPR;
                            coff = {6'b0, off[4:0]};
                        end else if (off >= 11'h600 && off <= 11'h61F) begin
                            tgt = TGT_ZERO;
                        end else begin
                            err = ERR_ADDR;
                        end
                    end else begin
                        err = ERR_ADDR;
                    end
                end
                CH_DEV: begin
                    if (addr <= ADDR_W'(DEV_NREGS)) tgt = TGT_DEV;
                    else                            err = ERR_ADDR;
                end
                CH_MEM: begin
                    if ({1'b0, addr} < (ADDR_W+1)'(MEM_WORDS)) tgt = TGT_MEM;
                    else                                        err = ERR_ADDR;
                end
                default: err = ERR_ADDR;
            endcase
        end
    end

endmodule

// File: rtl/dbgr_devregs.sv
`timescale 1ns/1ps
module dbgr_devregs #(
    parameter int unsigned DEV_NREGS = 4,
    parameter int unsigned IDX_W     = $clog2(DEV_NREGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             cpu_reset_hold,
    output logic             cpu_stall_req,
    output logic             cpu_reset_pulse
);
    typedef struct packed {
        logic [DEV_NREGS-1:0][31:0] scr;
        logic                       hold;
        logic                       stall;
        logic                       pulse;
    } dev_st_t;

    dev_st_t st_d, st_q;
    logic    is_ctrl;

    assign is_ctrl = (idx == IDX_W'(DEV_NREGS));

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_en) begin
            if (is_ctrl) begin
                st_d.hold  = wdata[0];
                st_d.stall = wdata[1];
                st_d.pulse = st_q.hold & ~wdata[0];
            end else begin
                for (int i = 0; i < int'(DEV_NREGS); i++) begin
                    if (idx == IDX_W'(i)) st_d.scr[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (is_ctrl) begin
            rdata = {30'b0, st_q.stall, st_q.hold};
        end else begin
            for (int i = 0; i < int'(DEV_NREGS); i++) begin
                if (idx == IDX_W'(i)) rdata = st_q.scr[i];
            end
        end
    end

    assign cpu_reset_hold  = st_q.hold;
    assign cpu_stall_req   = st_q.stall;
    assign cpu_reset_pulse = st_q.pulse;

    // R11: the one-shot only follows a 1->0 change of the hold bit
    a_r11_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_pulse |-> ($past(cpu_reset_hold) && !cpu_reset_hold));

    // R10: control outputs change only after a write
    a_r10_ctrl_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(cpu_reset_hold) && $stable(cpu_stall_req)));

    // R11: the one-shot never lasts two cycles
    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_pulse |=> !cpu_reset_pulse);

endmodule

// File: rtl/dbgr_memseq.sv
`timescale 1ns/1ps
module dbgr_memseq #(
    parameter int unsigned BADDR_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               we,
    input  logic [BADDR_W-1:0] baddr,
    input  logic [31:0]        wdata,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [BADDR_W-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic               last,
    output logic [31:0]        word_nxt
);
    localparam int unsigned BEATS = 4;
    localparam int unsigned CNT_W = $clog2(BEATS);

    typedef struct packed {
        logic               active;
        logic               we;
        logic [CNT_W-1:0]   cnt;
        logic [BADDR_W-1:0] addr;
        logic [31:0]        word;
    } seq_st_t;

    seq_st_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (sq_q.active) begin
            sq_d.word = {sq_q.word[23:0], sq_q.we ? 8'h00 : mem_rdata};
            sq_d.addr = sq_q.addr + 1'b1;
            sq_d.cnt  = sq_q.cnt + 1'b1;
            if (sq_q.cnt == CNT_W'(BEATS - 1)) sq_d.active = 1'b0;
        end else if (start) begin
            sq_d.active = 1'b1;
            sq_d.we     = we;
            sq_d.cnt    = '0;
            sq_d.addr   = baddr;
            sq_d.word   = we ? wdata : 32'h0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign mem_valid = sq_q.active;
    assign mem_we    = sq_q.active & sq_q.we;
    assign mem_addr  = sq_q.addr;
    assign mem_wdata = sq_q.word[31:24];
    assign last      = sq_q.active && (sq_q.cnt == CNT_W'(BEATS - 1));
    assign word_nxt  = sq_d.word;

    // R12: beats walk upward one byte at a time
    a_r12_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !last) |=> (mem_valid && mem_addr == $past(mem_addr) + 1'b1));

    // R14: no new transfer is launched over a running one
    a_r14_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !mem_valid);

    // R12: direction of a transfer holds for all its beats
    a_r12_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !last) |=> $stable(mem_we));

endmodule

// File: rtl/dbgr_top.sv
`timescale 1ns/1ps
module dbgr_top
    import dbgr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned MEM_WORDS = 1024,
    parameter int unsigned DEV_NREGS = 4,
    parameter int unsigned NPC_OFF   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic [1:0]        rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              core_re,
    output logic              core_we,
    output logic [1:0]        core_sel,
    output logic [10:0]       core_addr,
    output logic [31:0]       core_wdata,
    input  logic [31:0]       core_rdata,
    output logic              npc_clear,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W+1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              cpu_reset_hold,
    output logic              cpu_stall_req,
    output logic              cpu_reset_pulse
);
    localparam int unsigned BADDR_W = ADDR_W + 2;
    localparam int unsigned IDX_W   = $clog2(DEV_NREGS + 1);

    typedef struct packed {
        chain_e      chain;
        logic        busy;
        logic        done;
        err_e        err;
        logic [31:0] rdata;
    } top_st_t;

    top_st_t tq_d, tq_q;

    op_e                op;
    tgt_e               tgt;
    err_e               dec_err;
    csel_e              csel;
    logic [OFF_W-1:0]   coff;
    logic [BADDR_W-1:0] mem_baddr;
    logic               accept;
    logic               is_rd;
    logic               is_wr;
    logic               dev_wr;
    logic [31:0]        dev_rdata;
    logic               mem_start;
    logic               mem_last;
    logic [31:0]        mem_word_nxt;

    assign op     = op_e'(req_op);
    assign accept = req_valid & ~tq_q.busy;
    assign is_rd  = (op == OP_READ);
    assign is_wr  = (op == OP_WRITE);

    dbgr_decode #(
        .ADDR_W    (ADDR_W),
        .MEM_WORDS (MEM_WORDS),
        .DEV_NREGS (DEV_NREGS)
    ) i_decode (
        .chain     (tq_q.chain),
        .op        (op),
        .addr      (req_addr),
        .tgt       (tgt),
        .err       (dec_err),
        .csel      (csel),
        .coff      (coff),
        .mem_baddr (mem_baddr)
    );

    assign dev_wr    = accept && (tgt == TGT_DEV) && is_wr;
    assign mem_start = accept && (tgt == TGT_MEM);

    dbgr_devregs #(
        .DEV_NREGS (DEV_NREGS),
        .IDX_W     (IDX_W)
    ) i_devregs (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (dev_wr),
        .idx             (req_addr[IDX_W-1:0]),
        .wdata           (req_wdata),
        .rdata           (dev_rdata),
        .cpu_reset_hold  (cpu_reset_hold),
        .cpu_stall_req   (cpu_stall_req),
        .cpu_reset_pulse (cpu_reset_pulse)
    );

    dbgr_memseq #(
        .BADDR_W (BADDR_W)
    ) i_memseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mem_start),
        .we        (is_wr),
        .baddr     (mem_baddr),
        .wdata     (req_wdata),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .last      (mem_last),
        .word_nxt  (mem_word_nxt)
    );

    always_comb begin
        tq_d      = tq_q;
        tq_d.done = 1'b0;
        if (tq_q.busy && mem_last) begin
            tq_d.busy  = 1'b0;
            tq_d.done  = 1'b1;
            tq_d.err   = ERR_OK;
            tq_d.rdata = mem_we ? 32'h0 : mem_word_nxt;
        end else if (accept) begin
            tq_d.done  = 1'b1;
            tq_d.err   = dec_err;
            tq_d.rdata = 32'h0;
            unique case (tgt)
                TGT_CHAIN: begin
                    if (req_wdata < 32'(NUM_CHAIN)) tq_d.chain = chain_e'(req_wdata[1:0]);
                    else                            tq_d.err   = ERR_CHAIN;
                end
                TGT_CORE: if (is_rd) tq_d.rdata = core_rdata;
                TGT_DEV:  if (is_rd) tq_d.rdata = dev_rdata;
                TGT_MEM: begin
                    tq_d.done = 1'b0;
                    tq_d.busy = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tq_q <= '0;
        else        tq_q <= tq_d;
    end

    assign core_re    = accept && (tgt == TGT_CORE) && is_rd;
    assign core_we    = accept && (tgt == TGT_CORE) && is_wr;
    assign core_sel   = csel;
    assign core_addr  = coff;
    assign core_wdata = req_wdata;
    assign npc_clear  = core_we && (csel == CSEL_SPR) && (coff == OFF_W'(NPC_OFF));

    assign rsp_done  = tq_q.done;
    assign rsp_err   = tq_q.err;
    assign rsp_rdata = tq_q.rdata;

    // R2: an error completion never carries data
    a_r2_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err != 2'd0) |-> (rsp_rdata == 32'h0));

    // R6: a write never reaches special register offset 0
    a_r6_no_write_off0: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we && core_sel == 2'd1) |-> (core_addr != 11'd0));

    // R13: memory beats stay inside the valid range
    a_r13_mem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ({1'b0, mem_addr} < (BADDR_W+1)'(MEM_WORDS * 4)));

    // R14: core strobes stay quiet during a memory transfer
    a_r14_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (!core_re && !core_we && !npc_clear));

    // R2: a memory transfer completes right after its last beat
    a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_addr[1:0] == 2'd3) |=> rsp_done);

endmodule

// File: tb/test_dbgr_top.sv
`timescale 1ns/1ps
module test_dbgr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [1:0]  rsp_err;
    logic [31:0] rsp_rdata;
    logic        core_re, core_we;
    logic [1:0]  core_sel;
    logic [10:0] core_addr;
    logic [31:0] core_wdata;
    logic [31:0] core_rdata;
    logic        npc_clear;
    logic        mem_valid, mem_we;
    logic [17:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        cpu_reset_hold, cpu_stall_req, cpu_reset_pulse;

    always #10 clk = ~clk;

    dbgr_top i_dbgr_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .core_re(core_re),
        .core_we(core_we), .core_sel(core_sel), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .npc_clear(npc_clear),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_reset_hold(cpu_reset_hold), .cpu_stall_req(cpu_stall_req),
        .cpu_reset_pulse(cpu_reset_pulse)
    );

    // core register stub and byte memory model
    logic [7:0] mem_arr [0:4095];
    always_comb core_rdata = {16'hC0DE, 3'b000, core_sel, core_addr};
    always_comb mem_rdata  = mem_valid ? mem_arr[mem_addr[11:0]] : 8'h00;
    always @(posedge clk) if (mem_valid && mem_we) mem_arr[mem_addr[11:0]] <= mem_wdata;

    int beats = 0;
    int dones = 0;
    always @(posedge clk) if (mem_valid) beats++;
    always @(negedge clk) if (rsp_done) dones++;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    // values sampled in the request cycle and at completion
    logic        s_re, s_we, s_npc, s_pulse, s_hold, s_stall;
    logic [1:0]  s_sel;
    logic [10:0] s_addr;
    logic [31:0] s_wd;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [15:0] addr, input logic [31:0] wd,
                         output logic [1:0] err, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        beats = 0;
        #1;
        s_re = core_re; s_we = core_we; s_npc = npc_clear;
        s_sel = core_sel; s_addr = core_addr; s_wd = core_wdata;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        err = rsp_err; rd = rsp_rdata;
        s_pulse = cpu_reset_pulse; s_hold = cpu_reset_hold; s_stall = cpu_stall_req;
    endtask

    function automatic logic [31:0] winit(input int w);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r = {r[23:0], 8'((4 * w + k) ^ 8'h5A)};
        return r;
    endfunction

    function automatic logic [31:0] stub(input logic [1:0] sel, input logic [10:0] a);
        return {16'hC0DE, 3'b000, sel, a};
    endfunction

    logic [1:0]  e;
    logic [31:0] r;
    int          c;
    logic [31:0] shadow [0:15];
    logic [31:0] dshadow [0:3];

    initial begin
        for (int i = 0; i < 4096; i++) mem_arr[i] = 8'(i ^ 8'h5A);
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        #1;
        check("R2 reset done", {31'b0, rsp_done}, 0);
        check("R10 reset hold/stall", {30'b0, cpu_stall_req, cpu_reset_hold}, 0);
        check("R11 reset pulse", {31'b0, cpu_reset_pulse}, 0);
        check("R12 reset mem_valid", {31'b0, mem_valid}, 0);
        rst_n = 1'b1;

        // R1 default chain, R4 group 6
        do_op(2'd0, {5'd6, 11'h012}, 0, e, r, c);
        check("R4 group6 err", e, 0);
        check("R4 group6 re/sel/addr", {s_re, s_we, s_sel, s_addr}, {1'b1, 1'b0, 2'd0, 11'h012});
        check("R4 group6 rdata", r, stub(2'd0, 11'h012));
        check("R2 one-cycle done", c, 1);
        do_op(2'd0, {5'd3, 11'h005}, 0, e, r, c);
        check("R4 bad group err", e, 1);
        check("R4 bad group no strobe", {s_re, s_we}, 0);
        check("R2 error rdata zero", r, 0);

        // R5 special and general registers
        do_op(2'd0, 16'h0005, 0, e, r, c);
        check("R5 spr read", r, stub(2'd1, 11'd5));
        check("R5 spr sel", {s_re, s_sel}, {1'b1, 2'd1});
        do_op(2'd1, 16'h040A, 32'hDEAD0001, e, r, c);
        check("R5 gpr write strobe", {s_we, s_sel, s_addr}, {1'b1, 2'd2, 11'd10});
        check("R5 gpr write data", s_wd, 32'hDEAD0001);
        check("R5 gpr write err", e, 0);

        // R6 offset 0
        do_op(2'd1, 16'h0000, 32'h1, e, r, c);
        check("R6 write off0 err", e, 2);
        check("R6 write off0 no we", {31'b0, s_we}, 0);
        do_op(2'd0, 16'h0000, 0, e, r, c);
        check("R6 read off0", {30'b0, e}, 0);
        check("R6 read off0 data", r, stub(2'd1, 11'd0));

        // R7 zero window and holes
        do_op(2'd0, 16'h0610, 0, e, r, c);
        check("R7 read window", {e, r[29:0]}, 0);
        check("R7 read window no strobe", {s_re, s_we}, 0);
        do_op(2'd1, 16'h0605, 32'h55, e, r, c);
        check("R7 write window err", e, 0);
        check("R7 write window no strobe", {s_re, s_we}, 0);
        do_op(2'd0, 16'h0500, 0, e, r, c);
        check("R7 hole 0x500", e, 1);
        do_op(2'd0, 16'h0420, 0, e, r, c);
        check("R7 hole 0x420", e, 1);

        // R8 next-PC clear
        do_op(2'd1, 16'h0010, 32'h100, e, r, c);
        check("R8 npc write clears", {s_npc, s_we}, 2'b11);
        do_op(2'd1, 16'h0011, 32'h100, e, r, c);
        check("R8 other spr no clear", {31'b0, s_npc}, 0);

        // R1 invalid chain keeps selection, then trace
        do_op(2'd2, 0, 32'd9, e, r, c);
        check("R1 invalid chain err", e, 3);
        do_op(2'd0, {5'd6, 11'h001}, 0, e, r, c);
        check("R1 chain kept", {31'b0, s_re}, 1);
        do_op(2'd2, 0, 32'd1, e, r, c);
        check("R1 select trace", e, 0);
        do_op(2'd0, 16'h1234, 0, e, r, c);
        check("R3 trace read", {e, r[29:0]}, 0);
        check("R3 trace read no strobe", {s_re, s_we}, 0);
        do_op(2'd1, 16'h1234, 32'h9, e, r, c);
        check("R3 trace write err", e, 2);

        // R9 R10 R11 development chain
        do_op(2'd2, 0, 32'd2, e, r, c);
        for (int i = 0; i < 4; i++) dshadow[i] = 32'h0;
        for (int i = 0; i < 24; i++) begin
            int k = int'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) begin
                dshadow[k] = $urandom;
                do_op(2'd1, 16'(k), dshadow[k], e, r, c);
                check("R9 scratch write err", e, 0);
            end else begin
                do_op(2'd0, 16'(k), 0, e, r, c);
                check("R9 scratch read", r, dshadow[k]);
            end
        end
        do_op(2'd0, 16'd5, 0, e, r, c);
        check("R9 dev out of range", e, 1);
        do_op(2'd1, 16'd4, 32'hFFFF_FFFF, e, r, c);
        check("R10 hold/stall set", {s_stall, s_hold}, 2'b11);
        check("R11 no pulse on set", {31'b0, s_pulse}, 0);
        do_op(2'd0, 16'd4, 0, e, r, c);
        check("R10 ctrl readback", r, 32'h3);
        do_op(2'd1, 16'd4, 32'h2, e, r, c);
        check("R11 pulse on fall", {s_pulse, s_hold, s_stall}, 3'b101);
        @(negedge clk);
        check("R11 pulse one cycle", {31'b0, cpu_reset_pulse}, 0);
        do_op(2'd1, 16'd4, 32'h0, e, r, c);
        check("R11 no pulse when low", {s_pulse, s_stall}, 0);

        // R12 R13 memory chain
        do_op(2'd2, 0, 32'd3, e, r, c);
        do_op(2'd1, 16'd7, 32'h11223344, e, r, c);
        check("R2 mem write cycles", c, 5);
        check("R12 beats", beats, 4);
        check("R12 byte order", {mem_arr[28], mem_arr[29], mem_arr[30], mem_arr[31]}, 32'h11223344);
        do_op(2'd0, 16'd7, 0, e, r, c);
        check("R12 read back", r, 32'h11223344);
        do_op(2'd0, 16'd300, 0, e, r, c);
        check("R12 read init pattern", r, winit(300));
        do_op(2'd1, 16'd1023, 32'hCAFEF00D, e, r, c);
        do_op(2'd0, 16'd1023, 0, e, r, c);
        check("R13 last word ok", r, 32'hCAFEF00D);
        do_op(2'd0, 16'd1024, 0, e, r, c);
        check("R13 out of range err", e, 1);
        check("R13 no beats", beats, 0);
        check("R13 one-cycle err", c, 1);

        // R14 request during transfer ignored
        @(negedge clk);
        dones = 0;
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'd20; req_wdata = 32'hAABBCCDD;
        @(negedge clk);
        req_addr = 16'd21; req_wdata = 32'h01020304;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        check("R14 single done", dones, 1);
        check("R14 word 21 unchanged",
              {mem_arr[84], mem_arr[85], mem_arr[86], mem_arr[87]}, winit(21));
        check("R14 word 20 written",
              {mem_arr[80], mem_arr[81], mem_arr[82], mem_arr[83]}, 32'hAABBCCDD);

        // random memory traffic against a word shadow
        for (int i = 0; i < 16; i++) shadow[i] = winit(100 + i);
        for (int i = 0; i < 40; i++) begin
            int k = int'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) begin
                shadow[k] = $urandom;
                do_op(2'd1, 16'(100 + k), shadow[k], e, r, c);
                check("R12 random write cycles", c, 5);
            end else begin
                do_op(2'd0, 16'(100 + k), 0, e, r, c);
                check("R12 random read", r, shadow[k]);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule